// File: doc/BRIEF.md
# Pipelined FIFO Merge Sorter

A streaming sorter for batches of K unsigned keys. Keys enter one per clock on a valid/key stream. The sorted batch leaves on a second valid/key stream, with a marker on the first key of each batch. The design is a chain of log2 K merge stages, and each stage has a single comparator. Stage s receives sorted runs of length 2^s and merges each adjacent pair of runs into one run of twice that length. It holds the first run of the pair in a queue. Merging begins in the same cycle that the first key of the partner run arrives. When either run of the pair is exhausted, the stage passes the remaining keys of the other run straight through.

Because each stage waits only for one run, the whole chain adds little latency beyond the K loading cycles. The first sorted key appears K + log2 K − 1 cycles after the first key of its batch is accepted. Batches may follow each other with no gap. Idle cycles between batches are also allowed. Within a batch the K keys must arrive on consecutive cycles. Ties are taken from the earlier run, so the merge order is stable.

Top module: `fifo_merge_sorter`

## Requirements
- R1: While `in_valid` is high one key is accepted on every clock. A batch is K consecutive valid cycles, and a new batch may begin on the cycle right after the previous one ends. Output batches then also follow each other with no gap.
- R2: The first key of a batch appears on `out_valid`/`out_key` exactly K + log2 K − 1 cycles after the cycle in which its first key was accepted (19 cycles for K = 16). The other K − 1 keys follow on the next consecutive cycles.
- R3: Within an output batch, keys are in non-decreasing unsigned order.
- R4: Each output batch holds exactly the keys of its input batch, with every duplicate kept.
- R5: `out_first` is high together with the first key of every output batch and low on every other cycle.
- R6: While `rst_n` is low, `out_valid` and `out_first` are low. Keys of an incomplete batch that was loaded before reset never appear. The next batch after reset is sorted and framed as a fresh batch.
- R7: Any number of idle cycles may separate two batches. Latency is counted from each batch's own first key.
- R8: Batches that are already ascending, strictly descending or all equal are sorted correctly. These cases cover the exhaustion of either run and ties at every stage.
- R9: No stage queue is ever written when full or read when empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input key is present this cycle |
| in_key | input | KW | Input key, unsigned |
| out_valid | output | 1 | Output key is present this cycle |
| out_key | output | KW | Sorted output key |
| out_first | output | 1 | Marks the first key of each sorted batch |

## Verification
The critical overlap occurs when batches are back to back. Batch N+1 is still loading into the first stages while the last stage emits batch N. Inside each stage, a pair's final merge step also shares a cycle with the arrival of the next pair's first run, or with its partner run's first key. The bench provokes this with five batches in a row, including ties, reverse order and constant data. It judges the result from the output stream alone: every batch must match an independent sort, sit at the exact latency, and leave no gap and no marker error at the boundary between batches.

// File: rtl/msort_pkg.sv
package msort_pkg;

  // Which run the merge pulls from in a given cycle
  typedef enum logic [1:0] {
    MM_IDLE    = 2'd0,  // no pair being merged
    MM_COMPARE = 2'd1,  // both runs still have keys
    MM_DRAIN_A = 2'd2,  // second run exhausted, pass first run
    MM_DRAIN_B = 2'd3   // first run exhausted, pass second run
  } merge_mode_e;

  // Length of the runs that enter stage s (0-based)
  function automatic int run_len(input int s);
    return 1 << s;
  endfunction

  // Cycles from first accepted key to first sorted key
  function automatic int sort_latency(input int k);
    return k + $clog2(k) - 1;
  endfunction

endpackage

// File: rtl/msort_fifo.sv
module msort_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign head  = mem[rd_ptr];
  assign empty = (count_q == '0);
  assign full  = (count_q == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  // R9: a write into a full queue is only legal when a read frees a slot
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);
  // R9: never read an empty queue
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/msort_stage.sv
module msort_stage
  import msort_pkg::*;
#(
  parameter int W = 8,
  parameter int L = 1   // length of each incoming run
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_key,
  output logic         out_valid,
  output logic [W-1:0] out_key
);
  localparam int PW = $clog2(2 * L);      // position inside a pair
  localparam int TW = $clog2(L) + 1;      // keys taken from one run
  localparam int SW = TW + 1;             // keys taken from both runs

  // Tie goes to the earlier run: keeps the merge stable
  function automatic logic take_left(input logic [W-1:0] a, input logic [W-1:0] b);
    return a <= b;
  endfunction

  logic [PW-1:0] pos_q;
  logic          busy_q;
  logic [TW-1:0] ta_q, tb_q;
  logic          ov_q;
  logic [W-1:0]  ok_q;
  logic [SW-1:0] opos_q;

  // Named events
  logic          in_is_b, pair_start, merging, pair_last;
  logic          pick_a, pick_b, b_bypass;
  logic          push_a, pop_a, push_b, pop_b;
  logic [TW-1:0] ta, tb, ta_n, tb_n;
  logic [W-1:0]  a_head, b_head_q, b_head, emit_key;
  logic          a_empty, a_full, b_empty, b_full;
  merge_mode_e   mode;

  assign in_is_b    = pos_q[PW-1];
  assign pair_start = in_valid && (pos_q == PW'(L));
  assign merging    = busy_q || pair_start;

  assign ta = pair_start ? '0 : ta_q;
  assign tb = pair_start ? '0 : tb_q;

  always_comb begin
    if (!merging)            mode = MM_IDLE;
    else if (ta == TW'(L))   mode = MM_DRAIN_B;
    else if (tb == TW'(L))   mode = MM_DRAIN_A;
    else                     mode = MM_COMPARE;
  end

  // Second-run head: queued key, or the key arriving this cycle
  assign b_head = b_empty ? in_key : b_head_q;

  assign pick_a = (mode == MM_DRAIN_A) ||
                  ((mode == MM_COMPARE) && take_left(a_head, b_head));
  assign pick_b = merging && !pick_a;

  assign b_bypass = pick_b && b_empty;
  assign pop_a    = pick_a;
  assign pop_b    = pick_b && !b_empty;
  assign push_a   = in_valid && !in_is_b;
  assign push_b   = in_valid && in_is_b && !b_bypass;

  assign emit_key = pick_a ? a_head : b_head;
  assign ta_n     = ta + TW'(pick_a);
  assign tb_n     = tb + TW'(pick_b);
  assign pair_last = merging && ((SW'(ta_n) + SW'(tb_n)) == SW'(2 * L));

  msort_fifo #(.W(W), .DEPTH(2 * L)) u_run_a (
    .clk(clk), .rst_n(rst_n),
    .push(push_a), .din(in_key), .pop(pop_a),
    .head(a_head), .empty(a_empty), .full(a_full)
  );

  msort_fifo #(.W(W), .DEPTH(L)) u_run_b (
    .clk(clk), .rst_n(rst_n),
    .push(push_b), .din(in_key), .pop(pop_b),
    .head(b_head_q), .empty(b_empty), .full(b_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      busy_q <= 1'b0;
      ta_q   <= '0;
      tb_q   <= '0;
      ov_q   <= 1'b0;
      ok_q   <= '0;
      opos_q <= '0;
    end else begin
      if (in_valid) pos_q <= pos_q + PW'(1);
      busy_q <= merging && !pair_last;
      if (merging) begin
        ta_q <= ta_n;
        tb_q <= tb_n;
      end
      ov_q   <= merging;
      ok_q   <= emit_key;
      opos_q <= SW'(ta) + SW'(tb);
    end
  end

  assign out_valid = ov_q;
  assign out_key   = ok_q;

  // R1: when the second run is chosen with nothing queued, its key is arriving
  a_r1_b_key_present: assert property (@(posedge clk) disable iff (!rst_n)
    b_bypass |-> (in_valid && in_is_b));
  // R1: the first run of a pair is fully queued before the merge needs it
  a_r1_a_key_present: assert property (@(posedge clk) disable iff (!rst_n)
    pick_a |-> !a_empty);
  // R3: every merged run leaves in non-decreasing order
  a_r3_run_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && opos_q != '0) |-> ($past(ov_q) && ok_q >= $past(ok_q)));
  // R9: queue full flags seen only with a matching read
  a_r9_b_room: assert property (@(posedge clk) disable iff (!rst_n)
    (push_b && b_full) |-> pop_b);
  a_r9_a_room: assert property (@(posedge clk) disable iff (!rst_n)
    (push_a && a_full) |-> pop_a);

endmodule

// File: rtl/fifo_merge_sorter.sv
module fifo_merge_sorter
  import msort_pkg::*;
#(
  parameter int K  = 16,
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [KW-1:0] in_key,
  output logic          out_valid,
  output logic [KW-1:0] out_key,
  output logic          out_first
);
  localparam int NS = $clog2(K);

  logic          sv [NS+1];
  logic [KW-1:0] sk [NS+1];
  logic [NS-1:0] ocnt_q;

  assign sv[0] = in_valid;
  assign sk[0] = in_key;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    msort_stage #(.W(KW), .L(run_len(s))) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(sv[s]), .in_key(sk[s]),
      .out_valid(sv[s+1]), .out_key(sk[s+1])
    );
  end

  assign out_valid = sv[NS];
  assign out_key   = sk[NS];

  // Position of the current output key within its batch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ocnt_q <= '0;
    else if (out_valid) ocnt_q <= ocnt_q + NS'(1);
  end

  assign out_first = out_valid && (ocnt_q == '0);

  // R2: a started output batch keeps flowing every cycle until its last key
  a_r2_output_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ocnt_q != NS'(K - 1)) |=> out_valid);
  // R5: the batch marker never appears on two consecutive keys
  a_r5_first_once: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |=> !out_first);

endmodule

// File: tb/sim_fifo_merge_sorter.sv
module sim_fifo_merge_sorter;
  localparam int K   = 16;
  localparam int KW  = 8;
  localparam int LAT = K + $clog2(K) - 1;
  localparam int NB  = 7;
  localparam int MAXEV = 256;

  typedef logic [KW-1:0] batch_t [K];

  // Stimulus table: 0 mixed, 1 strictly descending, 2 all equal, 3 ascending
  localparam logic [KW-1:0] TAB [4][K] = '{
    '{8'd93, 8'd7, 8'd200, 8'd41, 8'd41, 8'd255, 8'd0, 8'd128,
      8'd66, 8'd13, 8'd180, 8'd99, 8'd3, 8'd150, 8'd77, 8'd21},
    '{8'd240, 8'd225, 8'd210, 8'd195, 8'd180, 8'd165, 8'd150, 8'd135,
      8'd120, 8'd105, 8'd90, 8'd75, 8'd60, 8'd45, 8'd30, 8'd15},
    '{8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A,
      8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A},
    '{8'd0, 8'd1, 8'd2, 8'd10, 8'd20, 8'd30, 8'd40, 8'd50,
      8'd60, 8'd70, 8'd80, 8'd90, 8'd100, 8'd200, 8'd254, 8'd255}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [KW-1:0] in_key = '0;
  logic          out_valid;
  logic [KW-1:0] out_key;
  logic          out_first;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  batch_t  bk [NB];
  int      in_cyc [NB];
  logic [KW-1:0] ev_key [MAXEV];
  logic    ev_first [MAXEV];
  int      ev_cyc [MAXEV];
  int      nev = 0;

  fifo_merge_sorter #(.K(K), .KW(KW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_key(in_key),
    .out_valid(out_valid), .out_key(out_key), .out_first(out_first)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && nev < MAXEV) begin
      ev_key[nev]   = out_key;
      ev_first[nev] = out_first;
      ev_cyc[nev]   = cyc;
      nev++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic batch_t ref_sort(input batch_t a);
    batch_t r = a;
    for (int i = 1; i < K; i++) begin
      for (int j = i; j > 0; j--) begin
        if (r[j-1] > r[j]) begin
          logic [KW-1:0] t = r[j];
          r[j] = r[j-1];
          r[j-1] = t;
        end
      end
    end
    return r;
  endfunction

  task automatic drive_batch(input int b);
    for (int i = 0; i < K; i++) begin
      @(negedge clk);
      if (i == 0) in_cyc[b] = cyc;
      in_valid = 1'b1;
      in_key   = bk[b][i];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_key   = '0;
    end
  endtask

  task automatic check_batch(input int b, input string tag);
    batch_t exp = ref_sort(bk[b]);
    int base = b * K;
    int bad_i = -1;
    bit asc = 1'b1;
    int nfirst = 0;
    for (int i = 0; i < K; i++)
      if (bad_i < 0 && ev_key[base+i] !== exp[i]) bad_i = i;
    for (int i = 1; i < K; i++)
      if (ev_key[base+i] < ev_key[base+i-1]) asc = 1'b0;
    for (int i = 1; i < K; i++)
      if (ev_first[base+i] !== 1'b0) nfirst++;
    // R4 / R8: keys equal the reference sort
    chk(bad_i < 0, tag, $sformatf("batch %0d key[%0d]", b, bad_i < 0 ? 0 : bad_i),
        bad_i < 0 ? 0 : int'(ev_key[base+bad_i]), bad_i < 0 ? 0 : int'(exp[bad_i]));
    chk(asc, "R3", $sformatf("batch %0d ascending", b), int'(asc), 1);
    chk(ev_cyc[base] - in_cyc[b] == LAT, "R2",
        $sformatf("batch %0d latency", b), ev_cyc[base] - in_cyc[b], LAT);
    chk(ev_cyc[base+K-1] - ev_cyc[base] == K - 1, "R2",
        $sformatf("batch %0d span", b), ev_cyc[base+K-1] - ev_cyc[base], K - 1);
    chk(ev_first[base] === 1'b1 && nfirst == 0, "R5",
        $sformatf("batch %0d first marks", b), int'(ev_first[base]) + nfirst, 1);
  endtask

  initial begin
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < K; i++) bk[b][i] = TAB[b][i];
    for (int i = 0; i < K; i++) begin
      bk[4][i] = KW'(((i * 7) % 4) * 16);          // heavy ties
      bk[5][i] = KW'((i * 37 + 11) & 255);
      bk[6][i] = KW'(((K - 1 - i) / 2) * 20);      // descending pairs of equals
    end

    // R6: outputs low while in reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0 && out_first === 1'b0, "R6", "reset outputs",
          int'(out_valid) + int'(out_first), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: five batches back to back
    for (int b = 0; b < 5; b++) drive_batch(b);
    idle(7);
    // R7: batch after idle gap
    drive_batch(5);
    idle(40);

    // R6: incomplete batch then reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_key   = KW'(i + 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0 && out_first === 1'b0, "R6", "mid-run reset outputs",
          int'(out_valid) + int'(out_first), 0);
    end
    rst_n = 1'b1;
    idle(2);
    drive_batch(6);
    idle(45);

    chk(nev == NB * K, "R6", "total output keys", nev, NB * K);
    if (nev >= NB * K) begin
      check_batch(0, "R4");
      check_batch(1, "R8");
      check_batch(2, "R8");
      check_batch(3, "R8");
      check_batch(4, "R4");
      check_batch(5, "R7");
      check_batch(6, "R6");
      for (int b = 0; b < 4; b++)
        chk(ev_cyc[(b+1)*K] - ev_cyc[b*K] == K, "R1",
            $sformatf("batch %0d to %0d spacing", b, b + 1),
            ev_cyc[(b+1)*K] - ev_cyc[b*K], K);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule